// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache with LRU Replacement

This block is a small read/write data cache between a processor load/store port and a word-addressed backing memory. It holds eight one-word blocks in four sets of two ways. Each way keeps a valid bit, a tag and a data word for every set. Each set keeps one replacement bit that names the way that was used least recently. A read that hits returns its word one cycle after the request is accepted. A read that misses fetches the word from the backing memory, writes it into a way of the indexed set and then returns it. Stores always write through to the backing memory. A store that hits also updates the cached word. A store that misses does not allocate a block.

Both the processor side and the memory side use a valid/ready request handshake. While `req_valid` is high and `req_ready` is low, the requester must hold the request unchanged. `req_ready` is low from the acceptance of any miss or store until that access completes, so it also serves as the processor's stall signal. Responses have no back-pressure: `rsp_valid` is a one-cycle pulse for each accepted read, and `mem_rsp_valid` is a one-cycle pulse from the memory. The memory must return read data at least one cycle after it accepts the request. Two counters of hits and misses make measured miss rates visible for a given access sequence.

Top module: `assoc2_cache`

## Requirements
- R1: After reset, `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0, both counters are 0 and no block is valid, so the first read of any address misses.
- R2: Address bits [1:0] are a byte offset that the lookup ignores. Bits [3:2] select the set and bits [31:4] form the tag, so addresses 0x08 and 0x0C fall in different sets.
- R3: A read hit raises `rsp_valid` in the cycle after acceptance, with the stored word. It issues no memory request and leaves `req_ready` high.
- R4: A read miss issues one memory read at the word-aligned address (low two bits zero). One cycle after `mem_rsp_valid`, it pulses `rsp_valid` with that word, and later reads of the address hit.
- R5: On a read miss, an invalid way of the set is filled before any valid way is evicted.
- R6: Each set's replacement bit points at the way not touched by the latest hit or fill. Reading 0x04, 0x24 and then 0x54 evicts 0x04 and keeps 0x24.
- R7: Five rounds of alternating reads of 0x04 and 0x24 after reset give exactly 2 misses and 8 hits, with 2 memory reads.
- R8: Every store issues one memory write carrying its address and data. A store hit also updates the cached word, so a following read hits with the new data.
- R9: A store miss does not allocate a block: a following read of that address misses and returns the written data from memory.
- R10: `mem_req_valid` and the request fields hold steady until `mem_req_ready`. With a memory that inserts L wait cycles, a read miss responds L+2 cycles after the first cycle following acceptance, and a store frees `req_ready` after L+1.
- R11: Every accepted access adds exactly one to either `hit_count` or `miss_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle; low means stall |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | Backing-memory request present |
| mem_req_ready | input | 1 | Backing memory takes the request |
| mem_req_write | output | 1 | 1 = write-through, 0 = fill read |
| mem_req_addr | output | 32 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write-through data |
| mem_rsp_valid | input | 1 | Fill data valid (one-cycle pulse) |
| mem_rsp_rdata | input | 32 | Fill data |
| hit_count | output | 16 | Hits since reset |
| miss_count | output | 16 | Misses since reset |

## Verification
The bench replays the three-address conflict in set 1. A victim choice that ignored the replacement bit, or flipped it the wrong way, would keep 0x04 and lose 0x24, and the expected hit would appear as a miss. It stores to a set that then fills, and reads the stored address again. A design that allocated on a store miss would hit there without a memory read, and one that skipped the write-through would return stale data. Reads with a non-zero byte offset and reads of neighbouring sets expose a wrong split of the index and tag fields. Varying the memory wait cycles exposes a design that drops or repeats a request while the handshake is stalled, because both the latency and the number of memory reads would change.

// File: rtl/c2_cache_pkg.sv
package c2_cache_pkg;
  localparam int NUM_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR_REQ  = 2'd3
  } c2_state_e;
endpackage

// File: rtl/c2_way_store.sv
module c2_way_store #(
  parameter int SET_W  = 2,
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic              lk_valid,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data;
    end
  end

  assign lk_valid = valid_q[lk_set];
  assign lk_hit   = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);
  assign lk_data  = data_q[lk_set];
endmodule

// File: rtl/c2_lru_bits.sv
module c2_lru_bits #(
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] q_set,
  output logic             q_lru,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic             upd_used
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (upd_en) begin
      lru_q[upd_set] <= ~upd_used;
    end
  end

  assign q_lru = lru_q[q_set];
endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache
  import c2_cache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_SETS = 4,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WA_W  = ADDR_W - OFF_W;
  localparam int TAG_W = WA_W - SET_W;

  c2_state_e         state_q;
  logic [WA_W-1:0]   held_wa_q;
  logic [DATA_W-1:0] held_wdata_q;
  logic              victim_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [CNT_W-1:0]  hit_cnt_q;
  logic [CNT_W-1:0]  miss_cnt_q;

  logic [SET_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [SET_W-1:0]  held_set;
  logic [TAG_W-1:0]  held_tag;
  logic              unused_offset;

  logic [NUM_WAYS-1:0] way_hit;
  logic [NUM_WAYS-1:0] way_valid;
  logic [NUM_WAYS-1:0] way_wen;
  logic [DATA_W-1:0]   way_data [NUM_WAYS];

  logic              accept;
  logic              any_hit;
  logic              hit_way;
  logic              victim;
  logic              lru_bit;
  logic              fill_now;

  logic [SET_W-1:0]  wr_set;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic              lru_upd;
  logic [SET_W-1:0]  lru_set;
  logic              lru_used;

  assign lk_set        = req_addr[OFF_W +: SET_W];
  assign lk_tag        = req_addr[ADDR_W-1 -: TAG_W];
  assign held_set      = held_wa_q[SET_W-1:0];
  assign held_tag      = held_wa_q[WA_W-1 -: TAG_W];
  assign unused_offset = ^req_addr[OFF_W-1:0];

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign any_hit   = |way_hit;
  assign hit_way   = way_hit[1];
  assign fill_now  = (state_q == ST_RD_WAIT) && mem_rsp_valid;

  // Empty way first, otherwise the least recently used one
  always_comb begin
    if (!way_valid[0])      victim = 1'b0;
    else if (!way_valid[1]) victim = 1'b1;
    else                    victim = lru_bit;
  end

  genvar w;
  generate
    for (w = 0; w < NUM_WAYS; w++) begin : g_way
      c2_way_store #(
        .SET_W (SET_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
      ) u_way (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_set  (lk_set),
        .lk_tag  (lk_tag),
        .lk_hit  (way_hit[w]),
        .lk_valid(way_valid[w]),
        .lk_data (way_data[w]),
        .wr_en   (way_wen[w]),
        .wr_set  (wr_set),
        .wr_tag  (wr_tag),
        .wr_data (wr_data)
      );
    end
  endgenerate

  c2_lru_bits #(.SET_W(SET_W)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .q_set   (lk_set),
    .q_lru   (lru_bit),
    .upd_en  (lru_upd),
    .upd_set (lru_set),
    .upd_used(lru_used)
  );

  // Write port and replacement update steering
  always_comb begin
    way_wen  = '0;
    wr_set   = lk_set;
    wr_tag   = lk_tag;
    wr_data  = req_wdata;
    lru_upd  = 1'b0;
    lru_set  = lk_set;
    lru_used = hit_way;
    if (accept && any_hit) begin
      lru_upd = 1'b1;
      if (req_write) begin
        way_wen[hit_way] = 1'b1;
      end
    end
    if (fill_now) begin
      way_wen           = '0;
      way_wen[victim_q] = 1'b1;
      wr_set            = held_set;
      wr_tag            = held_tag;
      wr_data           = mem_rsp_rdata;
      lru_upd           = 1'b1;
      lru_set           = held_set;
      lru_used          = victim_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      held_wa_q    <= '0;
      held_wdata_q <= '0;
      victim_q     <= 1'b0;
      rsp_valid_q  <= 1'b0;
      rsp_data_q   <= '0;
      hit_cnt_q    <= '0;
      miss_cnt_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            held_wa_q    <= req_addr[ADDR_W-1:OFF_W];
            held_wdata_q <= req_wdata;
            victim_q     <= victim;
            if (any_hit) hit_cnt_q  <= hit_cnt_q + 1'b1;
            else         miss_cnt_q <= miss_cnt_q + 1'b1;
            if (req_write) begin
              state_q <= ST_WR_REQ;
            end else if (any_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= way_data[hit_way];
            end else begin
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          if (mem_req_ready) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= mem_rsp_rdata;
            state_q     <= ST_IDLE;
          end
        end
        ST_WR_REQ: begin
          if (mem_req_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_req_write = (state_q == ST_WR_REQ);
  assign mem_req_addr  = {held_wa_q, {OFF_W{1'b0}}};
  assign mem_req_wdata = held_wdata_q;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_rdata     = rsp_data_q;
  assign hit_count     = hit_cnt_q;
  assign miss_count    = miss_cnt_q;
endmodule

// File: rtl/c2_cache_checker.sv
module c2_cache_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  p_rsp_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready && !req_write) ||
                   $past(mem_rsp_valid && !req_ready)));

  p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready && !req_write) && rsp_valid) |->
      (!mem_req_valid && req_ready));

  p_fill_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !req_ready && !mem_req_valid) |=> rsp_valid);

  p_store_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=>
      (!req_ready && mem_req_valid && mem_req_write));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_wdata)));

  p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_count != $past(hit_count), miss_count != $past(miss_count)}) ==
      ($past(req_valid && req_ready && rst_n) ? 1 : 0));
endmodule

bind assoc2_cache c2_cache_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/assoc2_cache_tb.sv
`timescale 1ns/1ps
module assoc2_cache_tb;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic [15:0] hit_count, miss_count;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int mem_lat = 1;
  int mem_rd_cnt = 0;
  int mem_wr_cnt = 0;
  logic [31:0] last_wr_addr, last_wr_data;
  logic [31:0] mem_arr [64];

  // {write, addr, wdata, expect_hit, expect_rdata}
  localparam logic [97:0] VEC [NV] = '{
    {1'b0, 32'h04, 32'h0, 1'b0, 32'hC0DE0001},
    {1'b0, 32'h24, 32'h0, 1'b0, 32'hC0DE0009},
    {1'b0, 32'h54, 32'h0, 1'b0, 32'hC0DE0015},
    {1'b0, 32'h24, 32'h0, 1'b1, 32'hC0DE0009},
    {1'b0, 32'h04, 32'h0, 1'b0, 32'hC0DE0001},
    {1'b0, 32'h07, 32'h0, 1'b1, 32'hC0DE0001},
    {1'b1, 32'h24, 32'h12345678, 1'b1, 32'h0},
    {1'b0, 32'h24, 32'h0, 1'b1, 32'h12345678},
    {1'b1, 32'h30, 32'h55AA55AA, 1'b0, 32'h0},
    {1'b0, 32'h30, 32'h0, 1'b0, 32'h55AA55AA},
    {1'b0, 32'h10, 32'h0, 1'b0, 32'hC0DE0004},
    {1'b0, 32'h30, 32'h0, 1'b1, 32'h55AA55AA},
    {1'b0, 32'h0C, 32'h0, 1'b0, 32'hC0DE0003},
    {1'b0, 32'h08, 32'h0, 1'b0, 32'hC0DE0002},
    {1'b0, 32'h0C, 32'h0, 1'b1, 32'hC0DE0003}
  };
  string vtag [NV] = '{"R4", "R5", "R6", "R6", "R6", "R2", "R8", "R8",
                       "R9", "R9", "R5", "R3", "R2", "R2", "R3"};

  always #10 clk = ~clk;

  assoc2_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Backing memory: L wait cycles before ready, data one cycle after
  initial begin
    bit pend = 0;
    int wcnt = 0;
    logic [31:0] pend_data = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    for (int i = 0; i < 64; i++) mem_arr[i] = 32'hC0DE0000 | i;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (!rst_n) begin
        wcnt = 0;
        pend = 0;
      end else if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = pend_data;
        pend = 0;
      end else if (mem_req_valid) begin
        if (wcnt < mem_lat) begin
          wcnt++;
        end else begin
          wcnt = 0;
          mem_req_ready = 1'b1;
          if (mem_req_write) begin
            mem_arr[mem_req_addr[7:2]] = mem_req_wdata;
            last_wr_addr = mem_req_addr;
            last_wr_data = mem_req_wdata;
            mem_wr_cnt++;
          end else begin
            pend = 1;
            pend_data = mem_arr[mem_req_addr[7:2]];
            mem_rd_cnt++;
          end
        end
      end
    end
  end

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    rd = '0;
    if (!w) begin
      while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
      rd = rsp_rdata;
    end else begin
      while (!req_ready && lat < 50) begin @(negedge clk); lat++; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int lat, h0, m0, mr0, mw0, exp_h, exp_m;
    logic vw, vh;
    logic [31:0] va, vd, ve;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 hit_count", hit_count, 0);
    chk("R1 miss_count", miss_count, 0);

    exp_h = 0; exp_m = 0;
    mem_lat = 1;
    for (int i = 0; i < NV; i++) begin
      {vw, va, vd, vh, ve} = VEC[i];
      h0 = hit_count; m0 = miss_count; mr0 = mem_rd_cnt; mw0 = mem_wr_cnt;
      access(vw, va, vd, rd, lat);
      if (vh) exp_h++; else exp_m++;
      chk({vtag[i], " hit delta"}, hit_count - h0, vh ? 1 : 0);
      chk({vtag[i], " miss delta"}, miss_count - m0, vh ? 0 : 1);
      if (vw) begin
        chk("R8 one memory write", mem_wr_cnt - mw0, 1);
        chk("R8 write data", last_wr_data, vd);
        chk("R8 write addr", last_wr_addr, va);
        chk("R10 store latency", lat, mem_lat + 1);
      end else begin
        chk({vtag[i], " read data"}, rd, ve);
        chk({vtag[i], " memory reads"}, mem_rd_cnt - mr0, vh ? 0 : 1);
        chk("R10 read latency", lat, vh ? 0 : mem_lat + 2);
      end
    end
    chk("R11 total hits", hit_count, exp_h);
    chk("R11 total misses", miss_count, exp_m);

    // R1: reset clears valid bits and counters
    do_reset();
    @(negedge clk);
    chk("R1 counters cleared", {hit_count, miss_count}, 0);
    access(1'b0, 32'h07, 32'h0, rd, lat);
    chk("R1 first read misses", miss_count, 1);
    chk("R4 aligned fill data", rd, 32'hC0DE0001);

    // R7 alternating loop with slower memory
    do_reset();
    mem_lat = 3;
    mr0 = mem_rd_cnt;
    for (int k = 0; k < 5; k++) begin
      access(1'b0, 32'h04, 32'h0, rd, lat);
      if (k == 0) chk("R10 slow read latency", lat, 5);
      access(1'b0, 32'h24, 32'h0, rd, lat);
    end
    chk("R7 misses", miss_count, 2);
    chk("R7 hits", hit_count, 8);
    chk("R7 memory reads", mem_rd_cnt - mr0, 2);

    finish_run();
  end
endmodule